// File: doc/BRIEF.md
# In-Order Pipeline Interlock Controller

This block holds the stall and advance control for a five-stage, in-order instruction pipeline: fetch, decode, execute, memory and writeback. Instruction descriptors arrive one at a time. Each descriptor carries an operation class, two source register numbers, an optional destination register and a tag. Every cycle the controller decides which stage moves forward, which stage holds, and where an empty slot is inserted. The datapath alongside it uses these decisions to steer its own pipeline registers.

Loads and stores stay in the memory stage for three cycles. While such an operation is counting down, every stage before it stays frozen. A branch stays in execute for two cycles. An instruction may move into decode even when one of its operands has not been written yet. Operand readiness is tested only when the instruction tries to move into execute. One bypass exists: a result leaving the memory stage can feed an instruction entering execute in the same cycle that the producer sits in writeback. There is no other forwarding.

Besides the per-stage valid, hold and bubble signals, the block exports the tag held in every stage. A checker can therefore follow each instruction through the pipe.

Top module: `pipe_interlock`

## Requirements
- R1: An active-high synchronous reset empties every stage, clears the memory and branch counters and drops every pending register write. After reset, no stale write delays any instruction.
- R2: Stages are numbered 0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback. Classes are coded 0 ALU, 1 load, 2 store, 3 branch. With no conflict, an instruction spends one cycle in each stage, in order. It enters fetch in the cycle after it is offered while `accept_o` is high. Stage s reports its tag on `stg_tag_o[s*TW +: TW]`.
- R3: A load or store occupies the memory stage for exactly three cycles.
- R4: A branch occupies the execute stage for exactly two cycles.
- R5: While a load or store still has memory cycles left, fetch, decode and execute do not change and `accept_o` is low.
- R6: An instruction moves from fetch to decode as soon as decode is free, whatever its operands.
- R7: An instruction reading a register that an older in-flight instruction writes enters execute no earlier than the cycle in which that producer sits in writeback. If the producer leaves memory in the same cycle, the consumer enters execute then.
- R8: Register 0 never causes a wait, as a source or as a destination.
- R9: An instruction writing a register that an older in-flight instruction also writes enters execute no earlier than the cycle after that older writer finishes writeback.
- R10: `stg_hold_o[s]` is high when stage s keeps its valid instruction across the coming edge. `stg_bub_o[s-1]` (s = 1..4) is high when stage s will be empty next cycle while stage s-1 keeps its instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A descriptor is offered |
| in_cls | input | 2 | Operation class (0 ALU, 1 load, 2 store, 3 branch) |
| in_src1 | input | RW | First source register |
| in_src2 | input | RW | Second source register |
| in_wr | input | 1 | Instruction writes a destination |
| in_dst | input | RW | Destination register |
| in_tag | input | TW | Identifier carried through the stages |
| accept_o | output | 1 | Fetch takes the offered descriptor at the next edge |
| stg_valid_o | output | 5 | Per-stage occupancy, bit s = stage s |
| stg_hold_o | output | 5 | Per-stage hold for the coming edge |
| stg_bub_o | output | 4 | Empty slot enters stage s+1 at the coming edge |
| stg_tag_o | output | 5*TW | Tag held in each stage |

## Verification
All stage contents are registered. A descriptor offered while `accept_o` is high shows up in the fetch trace one edge later, and the stage it reaches in each later cycle follows from the schedule. The hold and bubble outputs describe the coming edge, so they are compared against the predicted occupancy of the next cycle, not the current one. The bench computes, for every instruction, the entry cycle of each stage with a recurrence that models freeze windows, execute-entry waits and in-order succession. It samples on the falling edge with a cycle index counted from reset release, so every comparison lines up with the registered outputs.

// File: rtl/pipe_interlock.sv
module pipe_interlock #(
  parameter int NREG = 8,
  parameter int TW   = 4,
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      in_cls,
  input  logic [RW-1:0]   in_src1,
  input  logic [RW-1:0]   in_src2,
  input  logic            in_wr,
  input  logic [RW-1:0]   in_dst,
  input  logic [TW-1:0]   in_tag,
  output logic            accept_o,
  output logic [4:0]      stg_valid_o,
  output logic [4:0]      stg_hold_o,
  output logic [3:0]      stg_bub_o,
  output logic [5*TW-1:0] stg_tag_o
);

  localparam logic [1:0] C_ALU = 2'd0;
  localparam logic [1:0] C_LD  = 2'd1;
  localparam logic [1:0] C_ST  = 2'd2;
  localparam logic [1:0] C_BR  = 2'd3;

  typedef struct packed {
    logic          v;
    logic [1:0]    cls;
    logic [RW-1:0] s1;
    logic [RW-1:0] s2;
    logic          wr;
    logic [RW-1:0] dst;
    logic [TW-1:0] tag;
  } slot_t;

  slot_t f_q, d_q, e_q, in_slot;
  logic            m_v, m_wr, w_v, w_wr, ecnt;
  logic [1:0]      m_cls, w_cls, mcnt;
  logic [RW-1:0]   m_dst, w_dst;
  logic [TW-1:0]   m_tag, w_tag;
  logic [NREG-1:0] pend, pend_n;

  logic frz, e_busy, m_go, e_go, d_go, f_go;
  logic rel1, rel2, raw1, raw2, waw, haz, e_mem;

  assign in_slot = '{v: in_valid, cls: in_cls, s1: in_src1, s2: in_src2,
                     wr: in_wr, dst: in_dst, tag: in_tag};

  assign frz    = m_v && (mcnt != 2'd0);
  assign m_go   = m_v && !frz;
  assign e_busy = e_q.v && ecnt;
  assign e_go   = e_q.v && !frz && !e_busy;
  assign e_mem  = (e_q.cls == C_LD) || (e_q.cls == C_ST);

  assign rel1 = (m_go && m_wr && m_dst == d_q.s1) || (w_v && w_wr && w_dst == d_q.s1);
  assign rel2 = (m_go && m_wr && m_dst == d_q.s2) || (w_v && w_wr && w_dst == d_q.s2);
  assign raw1 = (d_q.s1 != '0) && pend[d_q.s1] && !rel1;
  assign raw2 = (d_q.s2 != '0) && pend[d_q.s2] && !rel2;
  assign waw  = d_q.wr && (d_q.dst != '0) && pend[d_q.dst]
                && !(w_v && w_wr && w_dst == d_q.dst);
  assign haz  = raw1 || raw2 || waw;

  assign d_go     = d_q.v && !frz && !e_busy && !haz;
  assign f_go     = f_q.v && !frz && (!d_q.v || d_go);
  assign accept_o = !frz && (!f_q.v || f_go);

  assign stg_valid_o = {w_v, m_v, e_q.v, d_q.v, f_q.v};
  assign stg_hold_o  = {1'b0, frz, e_q.v && !e_go, d_q.v && !d_go, f_q.v && !f_go};
  assign stg_bub_o   = {frz,
                        e_q.v && !e_go && !frz,
                        d_q.v && !d_go && (!e_q.v || e_go),
                        f_q.v && !f_go && (!d_q.v || d_go)};
  assign stg_tag_o   = {w_tag, m_tag, e_q.tag, d_q.tag, f_q.tag};

  always_comb begin
    pend_n = pend;
    if (w_v && w_wr) pend_n[w_dst] = 1'b0;
    if (d_go && d_q.wr && d_q.dst != '0) pend_n[d_q.dst] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q   <= '0;
      d_q   <= '0;
      e_q   <= '0;
      ecnt  <= 1'b0;
      m_v   <= 1'b0;
      m_cls <= C_ALU;
      m_wr  <= 1'b0;
      m_dst <= '0;
      m_tag <= '0;
      mcnt  <= 2'd0;
      w_v   <= 1'b0;
      w_cls <= C_ALU;
      w_wr  <= 1'b0;
      w_dst <= '0;
      w_tag <= '0;
      pend  <= '0;
    end else begin
      if (accept_o) f_q <= in_slot;
      if (f_go) d_q <= f_q;
      else if (d_go) d_q <= '0;
      if (d_go) e_q <= d_q;
      else if (e_go) e_q <= '0;
      ecnt <= d_go && (d_q.cls == C_BR);
      if (e_go) begin
        m_v   <= 1'b1;
        m_cls <= e_q.cls;
        m_wr  <= e_q.wr;
        m_dst <= e_q.dst;
        m_tag <= e_q.tag;
        mcnt  <= e_mem ? 2'd2 : 2'd0;
      end else if (m_go) begin
        m_v <= 1'b0;
      end else if (frz) begin
        mcnt <= mcnt - 2'd1;
      end
      w_v <= m_go;
      if (m_go) begin
        w_cls <= m_cls;
        w_wr  <= m_wr;
        w_dst <= m_dst;
        w_tag <= m_tag;
      end
      pend <= pend_n;
    end
  end

  // R2
  w_from_m_chk: assert property (@(posedge clk) disable iff (rst)
    w_v |-> ($past(m_v) && $past(m_tag) == w_tag));

  // R3
  mem_three_chk: assert property (@(posedge clk) disable iff (rst)
    (w_v && (w_cls == C_LD || w_cls == C_ST)) |->
      ($past(m_v, 3) && $past(m_tag, 3) == w_tag &&
       $past(m_tag, 2) == w_tag && $past(m_tag, 1) == w_tag));

  // R4
  br_two_chk: assert property (@(posedge clk) disable iff (rst)
    (e_q.v && e_q.cls == C_BR && $past(d_go)) |=> (e_q.v && $stable(e_q.tag)));

  // R5
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    frz |=> ($stable(f_q) && $stable(d_q) && $stable(e_q)));

  // R7
  raw_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(d_go) && e_q.v && m_v && m_wr && m_dst != '0) |->
      (m_dst != e_q.s1 && m_dst != e_q.s2));

  // R10
  bub_mem_chk: assert property (@(posedge clk) disable iff (rst)
    stg_bub_o[2] |=> !m_v);

endmodule

// File: tb/pipe_interlock_bench.sv
`timescale 1ns/1ps
module pipe_interlock_bench;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_cls = '0;
  logic [2:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
  logic in_wr = 1'b0;
  logic [TW-1:0] in_tag = '0;
  logic accept_o;
  logic [4:0] stg_valid_o, stg_hold_o;
  logic [3:0] stg_bub_o;
  logic [5*TW-1:0] stg_tag_o;

  pipe_interlock u_pipe_interlock (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls),
    .in_src1(in_src1), .in_src2(in_src2), .in_wr(in_wr), .in_dst(in_dst),
    .in_tag(in_tag), .accept_o(accept_o), .stg_valid_o(stg_valid_o),
    .stg_hold_o(stg_hold_o), .stg_bub_o(stg_bub_o), .stg_tag_o(stg_tag_o)
  );

  always #10 clk = ~clk;

  int nvec = 0, nbad = 0;
  int n;
  int pc[8], ps1[8], ps2[8], pdst[8], pwr[8];
  string lab[8];
  int T[8][6];
  int act[8][5];

  task automatic check(input bit ok, input string rq, input int a, input int e, input string what);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, a, e);
    end
  endtask

  function automatic bit is_mem(int c);
    return c == 1 || c == 2;
  endfunction

  function automatic bit frozen(int c, int upto);
    for (int j = 0; j < upto; j++)
      if (is_mem(pc[j]) && c >= T[j][3] && c <= T[j][3] + 1) return 1'b1;
    return 1'b0;
  endfunction

  function automatic void schedule();
    for (int i = 0; i < n; i++) begin
      int e;
      if (i == 0) begin T[0][0] = 1; T[0][1] = 2; end
      else begin T[i][0] = T[i-1][1]; T[i][1] = T[i-1][2]; end
      e = T[i][1] + 1;
      if (i > 0 && T[i-1][3] > e) e = T[i-1][3];
      for (int j = 0; j < i; j++) begin
        if (pwr[j] != 0 && pdst[j] != 0) begin
          if ((pdst[j] == ps1[i] || pdst[j] == ps2[i]) && T[j][4] > e) e = T[j][4];
          if (pwr[i] != 0 && pdst[i] == pdst[j] && T[j][4] + 1 > e) e = T[j][4] + 1;
        end
      end
      while (frozen(e - 1, i)) e++;
      T[i][2] = e;
      T[i][3] = e + ((pc[i] == 3) ? 2 : 1);
      if (i > 0 && T[i-1][4] > T[i][3]) T[i][3] = T[i-1][4];
      T[i][4] = T[i][3] + (is_mem(pc[i]) ? 3 : 1);
      T[i][5] = T[i][4] + 1;
    end
  endfunction

  function automatic int occ(int s, int c);
    for (int i = 0; i < n; i++)
      if (T[i][s] <= c && c < T[i][s+1]) return i;
    return -1;
  endfunction

  task automatic set_ins(input int i, input int c, input int a, input int b,
                         input int w, input int d, input string l);
    pc[i] = c; ps1[i] = a; ps2[i] = b; pwr[i] = w; pdst[i] = d; lab[i] = l;
  endtask

  task automatic run_prog(input int stop_at);
    int k = 0;
    int last;
    schedule();
    for (int i = 0; i < 8; i++)
      for (int s = 0; s < 5; s++) act[i][s] = -1;
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    last = (stop_at >= 0) ? stop_at : T[n-1][5] + 1;
    for (int c = 0; c <= last; c++) begin
      if (c == 0) check(stg_valid_o == 5'd0 && accept_o, "R1", int'(stg_valid_o), 0, "empty after reset");
      if (frozen(c, n)) check(!accept_o, "R5", int'(accept_o), 0, "accept during memory freeze");
      for (int s = 0; s < 5; s++) begin
        int ex = occ(s, c);
        int nx = occ(s, c + 1);
        int tg = int'(stg_tag_o[s*TW +: TW]);
        bit v = stg_valid_o[s];
        bit eh = (ex >= 0) && (nx == ex);
        check(ex < 0 ? !v : (v && tg == ex), "R2", v ? tg : -1, ex, "stage occupancy");
        check(stg_hold_o[s] == eh, "R10", int'(stg_hold_o[s]), int'(eh), "hold");
        if (s > 0) begin
          int up = occ(s - 1, c);
          bit eb = (nx < 0) && (up >= 0) && (occ(s - 1, c + 1) == up);
          check(stg_bub_o[s-1] == eb, "R10", int'(stg_bub_o[s-1]), int'(eb), "bubble");
        end
        if (v && tg < n && act[tg][s] < 0) act[tg][s] = c;
      end
      if (accept_o && k < n) begin
        in_valid = 1'b1;
        in_cls = 2'(pc[k]); in_src1 = 3'(ps1[k]); in_src2 = 3'(ps2[k]);
        in_wr = pwr[k] != 0; in_dst = 3'(pdst[k]); in_tag = TW'(k);
        k++;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    if (stop_at < 0) begin
      for (int i = 0; i < n; i++)
        for (int s = 0; s < 5; s++) begin
          string rq = "R2";
          if (s == 0) rq = "R5";
          else if (s == 1) rq = "R6";
          else if (s == 2) rq = lab[i];
          else if (s == 3 && pc[i] == 3) rq = "R4";
          else if (s == 4 && is_mem(pc[i])) rq = "R3";
          check(act[i][s] == T[i][s], rq, act[i][s], T[i][s], "entry cycle");
        end
    end
  endtask

  task automatic load_loop();
    n = 6;
    set_ins(0, 1, 0, 0, 1, 3, "R6");
    set_ins(1, 1, 3, 0, 1, 1, "R7");
    set_ins(2, 0, 1, 0, 1, 1, "R7");
    set_ins(3, 0, 3, 2, 1, 4, "R6");
    set_ins(4, 2, 1, 3, 0, 0, "R7");
    set_ins(5, 3, 4, 0, 0, 0, "R7");
  endtask

  initial begin
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int d = 0; d < 5; d++) begin
          n = 4;
          set_ins(0, a, 2, 3, (a < 2 || d == 4) ? 1 : 0, (d == 4) ? 0 : 1, "R6");
          set_ins(1, b, 4, 5, (b < 2) ? 1 : 0, 7, "R6");
          if (d == 1) begin ps1[1] = 1; lab[1] = "R7"; end
          if (d == 2) begin ps2[1] = 1; lab[1] = "R7"; end
          if (d == 3) begin pwr[1] = 1; pdst[1] = 1; lab[1] = "R9"; end
          if (d == 4) begin ps1[1] = 0; ps2[1] = 0; pwr[1] = 1; pdst[1] = 0; lab[1] = "R8"; end
          set_ins(2, 0, 1, 7, 1, 6, "R7");
          set_ins(3, 2, 6, 1, 0, 0, "R7");
          run_prog(-1);
        end
    load_loop();
    run_prog(-1);
    n = 6;
    set_ins(0, 3, 0, 0, 0, 0, "R4");
    set_ins(1, 3, 0, 0, 0, 0, "R4");
    set_ins(2, 0, 0, 0, 1, 5, "R6");
    set_ins(3, 1, 5, 0, 1, 6, "R7");
    set_ins(4, 2, 6, 5, 0, 0, "R7");
    set_ins(5, 1, 0, 0, 1, 6, "R9");
    run_prog(-1);
    load_loop();
    run_prog(8);
    n = 2;
    set_ins(0, 0, 1, 3, 1, 2, "R1");
    set_ins(1, 0, 2, 0, 1, 3, "R7");
    run_prog(-1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule